// File: doc/BRIEF.md
# Expansion-bus write activity status timers

This block produces three read-only status flags that imitate the activity of a write FIFO on an expansion bus. Host software polls them after it pushes words across the bus. Each write strobe opens or lengthens three staggered busy windows. The first window opens at once. The second opens a fixed delay later, and the third opens after a longer delay. Each window closes after its own length has elapsed. All timing is counted in clock ticks, and every tick constant is a parameter.

A burst is a run of writes during which a window stays open. A write in the middle of a burst never moves a pending opening time. Instead it adds that window's full length to the time the window has left before it closes. Each window is held as a down-counter with its own valid flag, and a window's flag changes on the edge where its counter reaches zero. A read strobe captures the three flags into a 32-bit status word. The flags sit at bits 5, 4 and 0 of that word, and every other bit reads zero. The word keeps its value until the next read.

Top module: `fsq_status_timers`

## Requirements
- R1: After reset all windows are inactive and `readData` is zero; a read issued with no write since reset returns zero.
- R2: A write on edge W sets the fast flag (status bit 5) after edge W; with no further write it clears after edge W+FAST_LEN, so it is high for FAST_LEN cycles.
- R3: The middle flag (status bit 4) rises after edge W+MID_DELAY, where W is the first write of a burst, and stays high for MID_LEN cycles when no further write arrives.
- R4: The slow flag (status bit 0) rises after edge W+SLOW_DELAY and stays high for SLOW_LEN cycles when no further write arrives.
- R5: A write that arrives while a window is open adds that window's full length to its remaining time. Two writes in one burst therefore keep a flag high for twice its length, measured from its rise.
- R6: A write that arrives while a rise is still pending does not move the rise; the rise stays at the first write's edge plus the delay.
- R7: The remaining time of a window saturates at 2^CNT_W-1 ticks and never wraps. After writes on edges W..W+3 that saturate the slow window, the slow flag is last high after edge W+3+2^CNT_W-2.
- R8: A read strobe on edge R loads `readData` on that edge with the flags as they stood before edge R: bit 5 holds the fast flag, bit 4 the middle flag and bit 0 the slow flag. Bits 31..6 and 3..1 are zero.
- R9: Without a read strobe `readData` holds its value, even while the flags change.
- R10: A write on the very edge where a window would close keeps the flag high with no low cycle, and the window then runs for the flag's full length from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is counted in its rising edges |
| rstN | input | 1 | Synchronous active-low reset |
| wrStb | input | 1 | One-cycle strobe for each word written across the bus |
| rdStb | input | 1 | Status read strobe; captures the flags into `readData` |
| readData | output | 32 | Status word: bit 5 fast flag, bit 4 middle flag, bit 0 slow flag, all other bits zero |

## Verification
The bench builds the block with CNT_W=6, FAST_LEN=6, MID_DELAY=6, MID_LEN=16, SLOW_DELAY=12 and SLOW_LEN=42. These short windows let every burst and its drain fit in a few hundred cycles. The 6-bit counters bring saturation within reach: two writes to the slow window already exceed 63, so the no-wrap rule of R7 shows up as a measurable fall time. With these delays and lengths, a second write can land while a rise is still pending, inside an open window, and exactly on a closing edge.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  // Flag positions in the status word; software decodes these bits.
  localparam int FAST_POS = 5;
  localparam int MID_POS  = 4;
  localparam int SLOW_POS = 0;
  localparam int NUM_CH   = 3;

  // Strobes from a channel's control to its datapath.
  typedef struct packed {
    logic armOn;    // start the rise countdown (new burst, delayed window)
    logic armOff;   // load the close countdown for a new burst
    logic extOff;   // add one full window length to an open window
    logic fireOn;   // rise countdown reaches zero on this edge
    logic fireOff;  // close countdown reaches zero on this edge
    logic setNow;   // new burst on a window with no delay: flag up at once
  } chanCtl_t;

endpackage

// File: rtl/fsq_chan_ctrl.sv
module fsq_chan_ctrl
  import fsq_pkg::*;
#(
  parameter int ON_DELAY = 60
) (
  input  logic     wrStb,
  input  logic     onValid,
  input  logic     onLast,
  input  logic     offValid,
  input  logic     offLast,
  output chanCtl_t ctl
);

  localparam logic HAS_DELAY = (ON_DELAY != 0);

  logic newBurst;

  // A write opens a new burst only when no window is open for this flag.
  assign newBurst = wrStb && !offValid;

  always_comb begin
    ctl         = '0;
    ctl.armOn   = newBurst && HAS_DELAY;
    ctl.setNow  = newBurst && !HAS_DELAY;
    ctl.armOff  = newBurst;
    ctl.extOff  = wrStb && offValid;
    ctl.fireOn  = onValid && onLast;
    // A write on the closing edge extends the window instead of closing it.
    ctl.fireOff = offValid && offLast && !wrStb;
  end

endmodule

// File: rtl/fsq_chan_dp.sv
module fsq_chan_dp
  import fsq_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int ON_DELAY = 60,
  parameter int WIN_LEN  = 160
) (
  input  logic     clk,
  input  logic     rstN,
  input  chanCtl_t ctl,
  output logic     onValid,
  output logic     onLast,
  output logic     offValid,
  output logic     offLast,
  output logic     bitQ
);

  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int LEN_I  = (WIN_LEN > CMAX) ? CMAX : WIN_LEN;
  localparam int ON_I   = (ON_DELAY > CMAX) ? CMAX : ON_DELAY;
  localparam int ARM_I  = (ON_DELAY + WIN_LEN > CMAX) ? CMAX : (ON_DELAY + WIN_LEN);
  localparam logic [CNT_W-1:0] LEN_CNT = CNT_W'(LEN_I);
  localparam logic [CNT_W-1:0] ON_CNT  = CNT_W'(ON_I);
  localparam logic [CNT_W-1:0] ARM_CNT = CNT_W'(ARM_I);

  logic [CNT_W-1:0] offCnt;
  logic [CNT_W:0]   extSum;
  logic [CNT_W-1:0] extSat;

  // Remaining time minus this edge plus one full window, clipped at the top.
  assign extSum  = {1'b0, offCnt} + {1'b0, LEN_CNT} - (CNT_W+1)'(1);
  assign extSat  = extSum[CNT_W] ? {CNT_W{1'b1}} : extSum[CNT_W-1:0];
  assign offLast = (offCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offCnt   <= '0;
      offValid <= 1'b0;
    end else if (ctl.armOff) begin
      offCnt   <= ARM_CNT;
      offValid <= 1'b1;
    end else if (ctl.extOff) begin
      offCnt   <= extSat;
      offValid <= 1'b1;
    end else if (offValid) begin
      offCnt   <= offCnt - CNT_W'(1);
      if (ctl.fireOff) offValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          bitQ <= 1'b0;
    else if (ctl.fireOff)               bitQ <= 1'b0;
    else if (ctl.setNow || ctl.fireOn)  bitQ <= 1'b1;
  end

  generate
    if (ON_DELAY > 0) begin : g_rise
      logic [CNT_W-1:0] onCnt;
      logic             onValidQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          onCnt    <= '0;
          onValidQ <= 1'b0;
        end else if (ctl.armOn) begin
          onCnt    <= ON_CNT;
          onValidQ <= 1'b1;
        end else if (onValidQ) begin
          onCnt    <= onCnt - CNT_W'(1);
          if (ctl.fireOn) onValidQ <= 1'b0;
        end
      end

      assign onValid = onValidQ;
      assign onLast  = (onCnt == CNT_W'(1));

      // R6: writes during a pending rise leave the countdown alone.
      assert_rise_fixed_R6: assert property (@(posedge clk) disable iff (!rstN)
        (onValid && !onLast) |=> (onValid && onCnt == $past(onCnt) - CNT_W'(1)));
    end else begin : g_no_rise
      logic unusedArmOn;
      assign unusedArmOn = ctl.armOn;
      assign onValid     = 1'b0;
      assign onLast      = 1'b0;
    end
  endgenerate

  // R7: extending a window never shortens it (no wrap on saturation).
  assert_ext_no_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.extOff |=> (offValid && offCnt >= $past(offCnt)));

  // R5: a raised flag always has an open window behind it.
  assert_bit_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitQ |-> offValid);

  // R10: a write while the flag is up keeps it up on the next cycle.
  assert_no_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bitQ && ctl.extOff) |=> bitQ);

endmodule

// File: rtl/fsq_read_port.sv
module fsq_read_port
  import fsq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic [NUM_CH-1:0] chanBits,
  output logic [DATA_W-1:0] readData
);

  localparam logic [DATA_W-1:0] STAT_MASK =
    (DATA_W'(1) << FAST_POS) | (DATA_W'(1) << MID_POS) | (DATA_W'(1) << SLOW_POS);

  logic [DATA_W-1:0] wordNext;

  always_comb begin
    wordNext           = '0;
    wordNext[FAST_POS] = chanBits[0];
    wordNext[MID_POS]  = chanBits[1];
    wordNext[SLOW_POS] = chanBits[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN)      readData <= '0;
    else if (rdStb) readData <= wordNext;
  end

  // R8: only the three flag positions can ever be set.
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> ((readData & ~STAT_MASK) == '0));

  // R9: the word holds between reads.
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(readData));

endmodule

// File: rtl/fsq_status_timers.sv
module fsq_status_timers
  import fsq_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int FAST_LEN   = 60,
  parameter int MID_DELAY  = 60,
  parameter int MID_LEN    = 160,
  parameter int SLOW_DELAY = 120,
  parameter int SLOW_LEN   = 420
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStb,
  input  logic        rdStb,
  output logic [31:0] readData
);

  localparam int CH_DLY [NUM_CH] = '{0, MID_DELAY, SLOW_DELAY};
  localparam int CH_LEN [NUM_CH] = '{FAST_LEN, MID_LEN, SLOW_LEN};

  logic [NUM_CH-1:0] chanBits;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      chanCtl_t ctl;
      logic     onValid, onLast, offValid, offLast;

      fsq_chan_ctrl #(.ON_DELAY(CH_DLY[g])) u_ctrl (
        .wrStb   (wrStb),
        .onValid (onValid),
        .onLast  (onLast),
        .offValid(offValid),
        .offLast (offLast),
        .ctl     (ctl)
      );

      fsq_chan_dp #(
        .CNT_W   (CNT_W),
        .ON_DELAY(CH_DLY[g]),
        .WIN_LEN (CH_LEN[g])
      ) u_dp (
        .clk     (clk),
        .rstN    (rstN),
        .ctl     (ctl),
        .onValid (onValid),
        .onLast  (onLast),
        .offValid(offValid),
        .offLast (offLast),
        .bitQ    (chanBits[g])
      );
    end
  endgenerate

  fsq_read_port #(.DATA_W(32)) u_read (
    .clk     (clk),
    .rstN    (rstN),
    .rdStb   (rdStb),
    .chanBits(chanBits),
    .readData(readData)
  );

  // R2: every write leaves the fast flag up on the following cycle.
  assert_write_sets_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> chanBits[0]);

endmodule

// File: tb/fsq_status_timers_tb.sv
module fsq_status_timers_tb;

  localparam int CNT_W = 6;
  localparam int FLEN = 6, MDLY = 6, MLEN = 16, SDLY = 12, SLEN = 42;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int POS [3] = '{5, 4, 0};
  localparam int DLY [3] = '{0, MDLY, SDLY};
  localparam int LEN [3] = '{FLEN, MLEN, SLEN};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] readData;

  int nChk = 0, nFail = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsq_status_timers #(
    .CNT_W(CNT_W), .FAST_LEN(FLEN), .MID_DELAY(MDLY), .MID_LEN(MLEN),
    .SLOW_DELAY(SDLY), .SLOW_LEN(SLEN)
  ) u_dut (
    .clk(clk), .rstN(rstN), .wrStb(wr), .rdStb(rd), .readData(readData)
  );

  // Behavioural reference: remaining ticks per window, -1 when idle.
  int          onR [3];
  int          offR [3];
  bit          mBit [3];
  logic [31:0] mRead;

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin onR[c] = -1; offR[c] = -1; mBit[c] = 0; end
      mRead = '0;
    end else begin
      if (rd) begin
        mRead = '0;
        for (int c = 0; c < 3; c++) mRead[POS[c]] = mBit[c];
      end
      for (int c = 0; c < 3; c++) begin
        bit nb;
        nb = mBit[c];
        if (wr && offR[c] <= 0) begin
          if (DLY[c] == 0) begin nb = 1; offR[c] = sat(LEN[c]); end
          else begin onR[c] = DLY[c]; offR[c] = sat(DLY[c] + LEN[c]); end
        end else begin
          if (onR[c] > 0) begin
            onR[c]--;
            if (onR[c] == 0) begin nb = 1; onR[c] = -1; end
          end
          if (offR[c] > 0) begin
            if (wr) offR[c] = sat(offR[c] - 1 + LEN[c]);
            else begin
              offR[c]--;
              if (offR[c] == 0) begin nb = 0; offR[c] = -1; end
            end
          end
        end
        mBit[c] = nb;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-flag observation statistics, gathered from readData.
  int highCnt [3];
  int firstHi [3];
  int lastHi [3];

  task automatic clearStats();
    for (int c = 0; c < 3; c++) begin highCnt[c] = 0; firstHi[c] = -1; lastHi[c] = -1; end
  endtask

  // Compare against the model every cycle, away from the edges.
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      check("R2", int'(readData[5]), int'(mRead[5]));
      check("R3", int'(readData[4]), int'(mRead[4]));
      check("R4", int'(readData[0]), int'(mRead[0]));
      check("R8", int'(readData & 32'hFFFF_FFCE), 0);
      for (int c = 0; c < 3; c++) begin
        if (readData[POS[c]]) begin
          highCnt[c]++;
          if (firstHi[c] < 0) firstHi[c] = cyc;
          lastHi[c] = cyc;
        end
      end
    end
  end

  // Drive one cycle; returns the edge index the values are sampled on.
  task automatic drive(bit w, bit r, output int edgeIdx);
    @(negedge clk);
    wr = w; rd = r;
    edgeIdx = cyc + 1;
  endtask

  task automatic idle(int n);
    int e;
    for (int i = 0; i < n; i++) drive(0, 1, e);
  endtask

  initial begin
    int w0, w1, e;
    logic [31:0] held;
    clearStats();
    repeat (3) @(negedge clk);
    // R1: reset value, then a read with no write
    check("R1", int'(readData), 0);
    @(negedge clk); rstN = 1'b1;
    drive(0, 1, e);
    idle(2);
    check("R1", int'(readData), 0);

    // R2/R3/R4: single write
    clearStats();
    drive(1, 1, w0);
    idle(100);
    check("R2", highCnt[0], FLEN);
    check("R2", firstHi[0] - w0, 1);
    check("R3", highCnt[1], MLEN);
    check("R3", firstHi[1] - w0, MDLY + 1);
    check("R4", highCnt[2], SLEN);
    check("R4", firstHi[2] - w0, SDLY + 1);

    // R5/R6: second write three edges later
    clearStats();
    drive(1, 1, w0);
    idle(2);
    drive(1, 1, w1);
    idle(150);
    check("R5", highCnt[0], 2 * FLEN);
    check("R5", highCnt[1], 2 * MLEN);
    check("R6", firstHi[1] - w0, MDLY + 1);
    check("R6", firstHi[2] - w0, SDLY + 1);

    // R10: second write on the closing edge of the fast window
    clearStats();
    drive(1, 1, w0);
    idle(FLEN - 1);
    drive(1, 1, w1);
    idle(150);
    check("R10", w1 - w0, FLEN);
    check("R10", highCnt[0], 2 * FLEN);
    check("R10", lastHi[0] - firstHi[0] + 1, 2 * FLEN);

    // R7: four back-to-back writes saturate the slow window
    clearStats();
    drive(1, 1, w0);
    for (int i = 0; i < 3; i++) drive(1, 1, e);
    idle(160);
    check("R7", lastHi[2] - w0, 3 + CMAX);
    check("R7", firstHi[2] - w0, SDLY + 1);

    // R9: reads stop while flags change
    drive(1, 1, w0);
    idle(SDLY + 2);
    drive(0, 0, e);
    @(posedge clk); #2;
    held = readData;
    check("R9", int'(held[0]), 1);
    for (int i = 0; i < 12; i++) begin
      drive(i == 3, 0, e);
      @(posedge clk); #2;
      check("R9", int'(readData), int'(held));
    end
    idle(200);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule